// File: doc/BRIEF.md
# Bank Controller with Latched Calendar Clock

This block is the control logic of a cartridge memory mapper that also keeps time. The CPU writes to four command windows in the low 32 KiB of its address space. One window turns external RAM and clock access on or off. One sets a 7-bit ROM bank number for the switchable ROM area. One chooses what appears in the 8 KiB external window at 0xA000-0xBFFF: one of four RAM banks, or one of five clock registers. The last window arms and fires a snapshot of the clock. The block drives the ROM bank extension, the RAM bank extension, a RAM chip select and a clock select. It also returns read data for the mapped clock register.

The clock counts seconds, minutes, hours and a 9-bit day number, advanced by a one-cycle tick enable at 1 Hz. A halt bit freezes it. A sticky carry flag records that the day number has wrapped. Software reads the clock from a shadow copy, which changes only when a snapshot is taken, so all five fields are consistent while the live clock keeps running. Writes to a mapped clock register go straight to the live counters.

Top module: `bank_rtc_mapper`

## Requirements
- R1: After synchronous reset, rom_bank is 1, ram_bank is 0, ram_cs and rtc_sel are 0, rtc_rdata is 0xFF, and the live and shadow clock fields are all zero.
- R2: A write to 0x0000-0x1FFF whose low nibble is 0xA enables RAM and clock access, and any other value disables it. While access is disabled, ram_cs and rtc_sel stay 0, rtc_rdata reads 0xFF and clock register writes have no effect.
- R3: A write to 0x2000-0x3FFF stores data bits 6:0 as the ROM bank. rom_bank shows 1 when the stored value is 0 and shows the stored value otherwise, so 0x20, 0x40 and 0x60 come out as written. The new value is visible in the cycle after the write.
- R4: A write to 0x4000-0x5FFF stores data bits 3:0 as the window selector, and ram_bank always shows selector bits 1:0. With access enabled and the address in 0xA000-0xBFFF, selector 0-3 asserts ram_cs and selector 8-12 asserts rtc_sel. Any other selector asserts neither.
- R5: rtc_rdata presents the shadow copy of the mapped register. Selector 8 reads seconds, 9 minutes, 10 hours and 11 day bits 7:0. Selector 12 reads carry in bit 7, halt in bit 6 and day bit 8 in bit 0, with the other bits 0. Unused high bits of seconds, minutes and hours read 0.
- R6: A tick advances seconds by one at the next clock edge. Seconds and minutes wrap from 59 to 0, hours from 23 to 0 and the day number from 511 to 0. Each wrap carries into the next field.
- R7: The day wrap sets the carry flag. The flag stays set until software writes selector-12 data with bit 7 clear.
- R8: While the halt bit (selector-12 data bit 6) is set, ticks leave every live field unchanged.
- R9: A write in 0xA000-0xBFFF with access enabled and a clock register mapped loads that live field from the data byte. A tick that arrives in the same cycle is dropped.
- R10: A write of 0x01 to 0x6000-0x7FFF copies the live clock into the shadow only if the previous write to that window was 0x00. Any other write there disarms the sequence. The shadow stays unchanged between snapshots while the live clock keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| sec_tick | input | 1 | One-cycle enable, once per second |
| rom_bank | output | 7 | Effective switchable ROM bank |
| ram_bank | output | 2 | External RAM bank extension |
| ram_cs | output | 1 | RAM selected for the current address |
| rtc_sel | output | 1 | Clock register selected for the current address |
| rtc_rdata | output | 8 | Read data of the mapped clock register |

## Verification
Register state changes at the edge that samples a write or a tick, and the outputs derived from it show the new value in the cycle that follows. ram_cs and rtc_sel also follow cpu_addr combinationally within the same cycle. The bench drives each cycle's inputs just after the falling edge and compares every output one nanosecond later, against a cycle model advanced only at the rising edge. Clock values are therefore checked only after a snapshot sequence has completed: the clock field appears on rtc_rdata one cycle after the selector write that maps it, and the bench reads it exactly there.

// File: rtl/bank_rtc_pkg.sv
// Shared constants and types for the banked mapper with calendar clock.
// Assumes a 16-bit CPU address and an 8-bit data bus.
package bank_rtc_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int ROM_W  = 7;
    localparam int SEL_W  = 4;
    localparam int RAMB_W = 2;
    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HR_W   = 5;
    localparam int DAY_W  = 9;
    localparam int SEC_MOD = 60;
    localparam int MIN_MOD = 60;
    localparam int HR_MOD  = 24;

    // Address bits 15:13 pick the command or data window.
    localparam logic [2:0] WIN_ENABLE = 3'd0;
    localparam logic [2:0] WIN_ROM    = 3'd1;
    localparam logic [2:0] WIN_SEL    = 3'd2;
    localparam logic [2:0] WIN_LATCH  = 3'd3;
    localparam logic [2:0] WIN_EXT    = 3'd5;

    // Clock register index = selector minus 8.
    typedef enum logic [2:0] {
        CK_SEC   = 3'd0,
        CK_MIN   = 3'd1,
        CK_HR    = 3'd2,
        CK_DAYLO = 3'd3,
        CK_DAYHI = 3'd4
    } clk_reg_e;

    typedef struct packed {
        logic             carry;
        logic             halt;
        logic [DAY_W-1:0] days;
        logic [HR_W-1:0]  hrs;
        logic [MIN_W-1:0] mins;
        logic [SEC_W-1:0] secs;
    } rtc_time_t;
endpackage

// File: rtl/bank_rtc_ctrl.sv
// Command-window registers: access enable, ROM bank, window selector and
// the snapshot arming state. Assumes cpu_wr is high for one cycle per write.
module bank_rtc_ctrl
    import bank_rtc_pkg::*;
#(
    parameter int ROM_BITS = ROM_W,
    parameter int SEL_BITS = SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [2:0]          region,
    input  logic [DATA_W-1:0]   wdata,
    output logic                ram_en,
    output logic [ROM_BITS-1:0] rom_sel,
    output logic [SEL_BITS-1:0] map_sel,
    output logic                latch_fire
);
    logic armed;

    // Capture command writes into the window that the address decodes to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_en  <= 1'b0;
            rom_sel <= '0;
            map_sel <= '0;
            armed   <= 1'b0;
        end else if (wr) begin
            case (region)
                WIN_ENABLE: ram_en  <= (wdata[3:0] == 4'hA);
                WIN_ROM:    rom_sel <= wdata[ROM_BITS-1:0];
                WIN_SEL:    map_sel <= wdata[SEL_BITS-1:0];
                WIN_LATCH:  armed   <= (wdata == DATA_W'(0));
                default:    ;
            endcase
        end
    end

    // Snapshot fires on a 0x01 write that directly follows an arming 0x00.
    assign latch_fire = wr && (region == WIN_LATCH) && (wdata == DATA_W'(1)) && armed;
endmodule

// File: rtl/bank_rtc_core.sv
// Live calendar counters. A field write takes priority over the tick of the
// same cycle; the halt bit blocks ticks. Assumes tick is a one-cycle pulse.
module bank_rtc_core
    import bank_rtc_pkg::*;
#(
    parameter int SEC_LIM = SEC_MOD,
    parameter int MIN_LIM = MIN_MOD,
    parameter int HR_LIM  = HR_MOD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_stb,
    input  clk_reg_e          wr_idx,
    input  logic [DATA_W-1:0] wdata,
    output rtc_time_t         live
);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_LIM - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_LIM - 1);
    localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(HR_LIM - 1);
    localparam logic [DAY_W-1:0] DAY_LAST = '1;

    rtc_time_t nxt;

    // Ripple the one-second step through the fields, flagging a day wrap.
    always_comb begin
        nxt = live;
        if (live.secs == SEC_LAST) begin
            nxt.secs = '0;
            if (live.mins == MIN_LAST) begin
                nxt.mins = '0;
                if (live.hrs == HR_LAST) begin
                    nxt.hrs = '0;
                    if (live.days == DAY_LAST) begin
                        nxt.days  = '0;
                        nxt.carry = 1'b1;
                    end else begin
                        nxt.days = live.days + 1'b1;
                    end
                end else begin
                    nxt.hrs = live.hrs + 1'b1;
                end
            end else begin
                nxt.mins = live.mins + 1'b1;
            end
        end else begin
            nxt.secs = live.secs + 1'b1;
        end
    end

    // Apply a software field write, otherwise an enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
        end else if (wr_stb) begin
            case (wr_idx)
                CK_SEC:   live.secs <= wdata[SEC_W-1:0];
                CK_MIN:   live.mins <= wdata[MIN_W-1:0];
                CK_HR:    live.hrs  <= wdata[HR_W-1:0];
                CK_DAYLO: live.days[7:0] <= wdata;
                CK_DAYHI: begin
                    live.days[DAY_W-1] <= wdata[0];
                    live.halt          <= wdata[6];
                    live.carry         <= wdata[7];
                end
                default: ;
            endcase
        end else if (tick && !live.halt) begin
            live <= nxt;
        end
    end
endmodule

// File: rtl/bank_rtc_shadow.sv
// Readable snapshot of the live clock, loaded only when a snapshot fires.
module bank_rtc_shadow
    import bank_rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fire,
    input  rtc_time_t live,
    output rtc_time_t held
);
    // Hold the snapshot until the next completed arming sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (fire) held <= live;
    end
endmodule

// File: rtl/bank_rtc_mapper.sv
// Top level: address decode, bank outputs and clock readback. Assumes the
// RAM array, oscillator divider and battery switch sit outside this block.
module bank_rtc_mapper
    import bank_rtc_pkg::*;
#(
    parameter bit ZERO_TO_ONE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              sec_tick,
    output logic [ROM_W-1:0]  rom_bank,
    output logic [RAMB_W-1:0] ram_bank,
    output logic              ram_cs,
    output logic              rtc_sel,
    output logic [DATA_W-1:0] rtc_rdata
);
    logic [2:0]       region;
    logic             ram_en;
    logic [ROM_W-1:0] rom_sel;
    logic [SEL_W-1:0] map_sel;
    logic             latch_fire;
    logic             clk_mapped;
    logic             in_ext;
    rtc_time_t        live_time;
    rtc_time_t        shadow_time;

    assign region     = cpu_addr[ADDR_W-1 -: 3];
    assign in_ext     = (region == WIN_EXT);
    assign clk_mapped = map_sel[SEL_W-1] && (map_sel[2:0] <= 3'd4);

    bank_rtc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cpu_wr),
        .region     (region),
        .wdata      (cpu_wdata),
        .ram_en     (ram_en),
        .rom_sel    (rom_sel),
        .map_sel    (map_sel),
        .latch_fire (latch_fire)
    );

    bank_rtc_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sec_tick),
        .wr_stb (cpu_wr && rtc_sel),
        .wr_idx (clk_reg_e'(map_sel[2:0])),
        .wdata  (cpu_wdata),
        .live   (live_time)
    );

    bank_rtc_shadow u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (latch_fire),
        .live  (live_time),
        .held  (shadow_time)
    );

    // Bank zero either remaps to one or passes through, per parameter.
    generate
        if (ZERO_TO_ONE) begin : g_remap
            assign rom_bank = (rom_sel == '0) ? ROM_W'(1) : rom_sel;
        end else begin : g_plain
            assign rom_bank = rom_sel;
        end
    endgenerate

    assign ram_bank = map_sel[RAMB_W-1:0];
    assign ram_cs   = in_ext && ram_en && (map_sel[SEL_W-1:RAMB_W] == '0);
    assign rtc_sel  = in_ext && ram_en && clk_mapped;

    // Present the snapshot field picked by the selector.
    always_comb begin
        rtc_rdata = '1;
        if (ram_en && clk_mapped) begin
            case (clk_reg_e'(map_sel[2:0]))
                CK_SEC:   rtc_rdata = DATA_W'(shadow_time.secs);
                CK_MIN:   rtc_rdata = DATA_W'(shadow_time.mins);
                CK_HR:    rtc_rdata = DATA_W'(shadow_time.hrs);
                CK_DAYLO: rtc_rdata = shadow_time.days[7:0];
                CK_DAYHI: rtc_rdata = {shadow_time.carry, shadow_time.halt, 5'b0,
                                       shadow_time.days[DAY_W-1]};
                default:  rtc_rdata = '1;
            endcase
        end
    end
endmodule

// File: rtl/bank_rtc_checker.sv
// Temporal checks on the mapper, attached to every instance by bind.
module bank_rtc_checker
    import bank_rtc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_wr,
    input logic             sec_tick,
    input logic [ROM_W-1:0] rom_bank,
    input logic             ram_cs,
    input logic             rtc_sel,
    input logic             latch_fire,
    input rtc_time_t        live,
    input rtc_time_t        shadow
);
    p_rom_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_bank != '0);

    p_one_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_cs && rtc_sel));

    p_tick_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !cpu_wr && !live.halt && live.secs != SEC_W'(SEC_MOD - 1))
        |=> live.secs == $past(live.secs) + SEC_W'(1));

    p_carry_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live.carry && !cpu_wr) |=> live.carry);

    p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live.halt && !cpu_wr) |=> live == $past(live));

    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_fire |=> $stable(shadow));
endmodule

bind bank_rtc_mapper bank_rtc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_wr     (cpu_wr),
    .sec_tick   (sec_tick),
    .rom_bank   (rom_bank),
    .ram_cs     (ram_cs),
    .rtc_sel    (rtc_sel),
    .latch_fire (latch_fire),
    .live       (live_time),
    .shadow     (shadow_time)
);

// File: tb/tb_bank_rtc_mapper.sv
`timescale 1ns/1ps
module tb_bank_rtc_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        sec_tick = 1'b0;
    logic [6:0]  rom_bank;
    logic [1:0]  ram_bank;
    logic        ram_cs;
    logic        rtc_sel;
    logic [7:0]  rtc_rdata;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    bit m_en, m_arm;
    int m_rom, m_sel;
    int l_s, l_m, l_h, l_d; bit l_halt, l_carry;
    int s_s, s_m, s_h, s_d; bit s_halt, s_carry;

    always #2.5 clk = ~clk;

    bank_rtc_mapper dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .sec_tick(sec_tick), .rom_bank(rom_bank),
        .ram_bank(ram_bank), .ram_cs(ram_cs), .rtc_sel(rtc_sel), .rtc_rdata(rtc_rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit clk_map(input int s);
        return s >= 8 && s <= 12;
    endfunction

    function automatic int exp_rom();
        return (m_rom == 0) ? 1 : m_rom;
    endfunction

    function automatic int exp_rd();
        if (!(m_en && clk_map(m_sel))) return 8'hFF;
        case (m_sel)
            8:  return s_s;
            9:  return s_m;
            10: return s_h;
            11: return s_d & 8'hFF;
            default: return (int'(s_carry) << 7) | (int'(s_halt) << 6) | (s_d >> 8);
        endcase
    endfunction

    task automatic model_reset();
        m_en = 0; m_arm = 0; m_rom = 0; m_sel = 0;
        l_s = 0; l_m = 0; l_h = 0; l_d = 0; l_halt = 0; l_carry = 0;
        s_s = 0; s_m = 0; s_h = 0; s_d = 0; s_halt = 0; s_carry = 0;
    endtask

    // Advance the model by one rising edge, using pre-edge state throughout.
    task automatic model_edge(input int a, input int d, input bit w, input bit t);
        int reg_win = (a >> 13) & 7;
        bit ckwr = w && reg_win == 5 && m_en && clk_map(m_sel);
        if (w && reg_win == 3 && d == 1 && m_arm) begin
            s_s = l_s; s_m = l_m; s_h = l_h; s_d = l_d; s_halt = l_halt; s_carry = l_carry;
        end
        if (ckwr) begin
            case (m_sel)
                8:  l_s = d & 63;
                9:  l_m = d & 63;
                10: l_h = d & 31;
                11: l_d = (l_d & 256) | d;
                default: begin
                    l_d = (l_d & 255) | ((d & 1) << 8);
                    l_halt = d[6]; l_carry = d[7];
                end
            endcase
        end else if (t && !l_halt) begin
            if (l_s == 59) begin
                l_s = 0;
                if (l_m == 59) begin
                    l_m = 0;
                    if (l_h == 23) begin
                        l_h = 0;
                        if (l_d == 511) begin l_d = 0; l_carry = 1; end
                        else l_d++;
                    end else l_h++;
                end else l_m++;
            end else l_s++;
        end
        if (w) begin
            case (reg_win)
                0: m_en = ((d & 15) == 10);
                1: m_rom = d & 127;
                2: m_sel = d & 15;
                3: m_arm = (d == 0);
                default: ;
            endcase
        end
    endtask

    // One cycle: drive after the falling edge, compare, then take the rising edge.
    task automatic step(input int a, input int d, input bit w, input bit t);
        bit inx;
        cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_wr = w; sec_tick = t;
        #1;
        inx = ((a >> 13) & 7) == 5;
        chk("R3 rom_bank", rom_bank, exp_rom());
        chk("R4 ram_bank", ram_bank, m_sel & 3);
        chk("R4 ram_cs", ram_cs, inx && m_en && m_sel < 4);
        chk("R4 rtc_sel", rtc_sel, inx && m_en && clk_map(m_sel));
        chk("R5 rtc_rdata", rtc_rdata, exp_rd());
        @(posedge clk);
        model_edge(a, d, w, t);
        @(negedge clk);
    endtask

    task automatic snap();
        step(16'h6000, 0, 1, 0);
        step(16'h6000, 1, 1, 0);
    endtask

    // Map a clock register, then compare its readback with a literal value.
    task automatic expect_rd(input string tag, input int sel, input int exp);
        step(16'h4000, sel, 1, 0);
        cpu_addr = 16'hA000; cpu_wr = 0; sec_tick = 0;
        #1;
        chk(tag, rtc_rdata, exp);
        @(posedge clk);
        model_edge(16'hA000, 0, 0, 0);
        @(negedge clk);
    endtask

    task automatic put_clk(input int sel, input int d);
        step(16'h4000, sel, 1, 0);
        step(16'hA000, d, 1, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cpu_addr = 16'hA000; #1;
        chk("R1 rom_bank", rom_bank, 1);
        chk("R1 ram_cs", ram_cs, 0);
        chk("R1 rtc_sel", rtc_sel, 0);
        chk("R1 rtc_rdata", rtc_rdata, 8'hFF);
        @(negedge clk);
        step(16'h0000, 8'h0A, 1, 0);
        expect_rd("R1 shadow secs", 8, 0);
        expect_rd("R1 shadow dayhi", 12, 0);

        // R6 full carry chain and day wrap
        put_clk(8, 59); put_clk(9, 59); put_clk(10, 23); put_clk(11, 8'hFF); put_clk(12, 8'h01);
        step(16'h0100, 0, 0, 1);
        snap();
        expect_rd("R6 secs wrap", 8, 0);
        expect_rd("R6 mins wrap", 9, 0);
        expect_rd("R6 hrs wrap", 10, 0);
        expect_rd("R6 day low wrap", 11, 0);
        expect_rd("R7 carry set", 12, 8'h80);

        // R7 carry sticks through ticks, clears by software
        repeat (3) step(16'h0100, 0, 0, 1);
        snap();
        expect_rd("R7 carry held", 12, 8'h80);
        expect_rd("R6 secs count", 8, 3);
        put_clk(12, 8'h00);
        snap();
        expect_rd("R7 carry cleared", 12, 8'h00);

        // R8 halt freezes the clock
        put_clk(8, 10); put_clk(12, 8'h40);
        repeat (5) step(16'h0100, 0, 0, 1);
        snap();
        expect_rd("R8 halted secs", 8, 10);
        expect_rd("R8 halt bit", 12, 8'h40);
        put_clk(12, 8'h00);
        step(16'h0100, 0, 0, 1);
        snap();
        expect_rd("R8 resumed secs", 8, 11);

        // R9 write beats tick; writes ignored while disabled
        step(16'h4000, 8, 1, 0);
        step(16'hA000, 30, 1, 1);
        step(16'h0000, 8'h00, 1, 0);
        cpu_addr = 16'hA000; cpu_wr = 0; #1;
        chk("R2 disabled rdata", rtc_rdata, 8'hFF);
        chk("R2 disabled rtc_sel", rtc_sel, 0);
        @(negedge clk);
        step(16'hA000, 45, 1, 0);
        step(16'h0000, 8'h5A, 1, 0);
        snap();
        expect_rd("R9 write wins over tick", 8, 30);

        // R10 broken sequences do not snapshot; live keeps running
        put_clk(8, 5); snap();
        put_clk(8, 40);
        step(16'h6000, 0, 1, 0); step(16'h6000, 2, 1, 0); step(16'h6000, 1, 1, 0);
        step(16'h6000, 1, 1, 0);
        expect_rd("R10 no snapshot", 8, 5);
        step(16'h0100, 0, 0, 1);
        expect_rd("R10 shadow held", 8, 5);
        snap();
        expect_rd("R10 snapshot taken", 8, 41);

        // R3 bank values
        step(16'h2000, 8'h00, 1, 0); #0 chk("R3 zero maps to one", rom_bank, 1);
        step(16'h2000, 8'h20, 1, 0); chk("R3 bank 0x20", rom_bank, 8'h20);
        step(16'h2000, 8'h40, 1, 0); chk("R3 bank 0x40", rom_bank, 8'h40);
        step(16'h2000, 8'h60, 1, 0); chk("R3 bank 0x60", rom_bank, 8'h60);
        step(16'h2000, 8'h85, 1, 0); chk("R3 bit 7 dropped", rom_bank, 8'h05);

        // R4 selector values
        step(16'h4000, 2, 1, 0);
        step(16'hA000, 0, 0, 0);
        step(16'h4000, 5, 1, 0);
        step(16'hBFFF, 0, 0, 0);
        step(16'h4000, 13, 1, 0);
        step(16'hA123, 0, 0, 0);

        // Constrained random traffic checked against the model every cycle
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(9);
            int a, d;
            bit w = $urandom_range(1);
            bit t = ($urandom_range(2) == 0);
            case (r)
                0: begin a = 16'h0000; d = ($urandom_range(3) == 0) ? 8'h00 : 8'h0A; end
                1: begin a = 16'h2000 | $urandom_range(16'h1FFF); d = $urandom_range(255); end
                2, 3: begin a = 16'h4000; d = ($urandom_range(1) == 1) ? 8 + $urandom_range(4) : $urandom_range(15); end
                4: begin a = 16'h6000; d = $urandom_range(2); end
                5: begin a = 16'h8000 | $urandom_range(16'h1FFF); d = $urandom_range(255); end
                default: begin
                    a = 16'hA000 | $urandom_range(16'h1FFF);
                    case (m_sel)
                        8, 9: d = $urandom_range(59);
                        10:   d = $urandom_range(23);
                        default: d = $urandom_range(255);
                    endcase
                end
            endcase
            step(a, d, w, t);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule